// File: doc/BRIEF.md
# Interrupt Acceptance Window Controller

This block decides, every clock cycle, whether a pending and enabled interrupt may be accepted by a pipelined processor core. It receives decode hints from the instruction stream: a one-word conditional branch together with its condition outcome, the start and end of a repeat-prefixed loop, stop and wait instructions, and instruction completion. It also receives the interrupt request and enable lines, a memory wait-state stall, and the execution length of the instruction currently in flight.

The block closes the interrupt window in three cases. The first is the two instructions after a one-word branch whose condition was false. The second is the whole of a repeat loop, during which instruction fetch is also held. The third is the low-power states. After an interrupt is accepted, arbitration stays disabled for a blackout. The blackout covers the interrupted instruction's execution time, three forced NOP slots and the first cycles of the subroutine call that enters the handler. Every wait-state stall lengthens the blackout by one cycle. The accept decision is combinational from registered state and the current inputs, so a request that has been held pending is taken in the first cycle the window opens.

Top module: `int_accept_window`

## Requirements
- R1: After a synchronous reset, `arb_en` is 1 and `take_int`, `nop_inject`, `fetch_hold` and `wake` are 0, with the block in its run state.
- R2: A cycle with `bcc1_valid`=1 and `bcc1_taken`=0 closes the window from the next cycle. The window reopens in the cycle after the second later cycle with `instr_done`=1.
- R3: A cycle with `bcc1_valid`=1 and `bcc1_taken`=1 does not close the window.
- R4: The window is closed from the `rep_start` cycle up to and including the `rep_end` cycle. `fetch_hold` is 1 from the cycle after `rep_start` through the `rep_end` cycle, and 0 afterwards.
- R5: After a cycle with `stop_op`=1 (and no take), `take_int` and `wake` stay 0 whatever the request lines do, until reset.
- R6: After a cycle with `wait_op`=1 (and no take), a cycle with `irq_pend`=1 and `irq_en`=1 raises `wake` in that same cycle and returns the block to run. A request with `irq_en`=0 does not raise `wake`.
- R7: `take_int` is 1 exactly when `irq_pend`=1, `irq_en`=1, the window is open, `arb_en`=1 and the block is not stopped. A request held through a closed window is taken in the first open cycle.
- R8: After a take with `exec_len`=E, `arb_en` is 0 for exactly E+NOP_SLOTS+CALL_CYCLES unstalled cycles that follow. With the defaults and E=4, that is 10 cycles.
- R9: Each cycle with `ws_stall`=1 during the blackout holds the blackout and NOP counts, so the blackout grows by one cycle.
- R10: `nop_inject` is 1 for the NOP_SLOTS unstalled cycles that follow a take, and it stays 1 through any stall cycles in between.
- R11: `take_int` is a single-cycle pulse and is never 1 while `arb_en` is 0.
- R12: When a take and `stop_op` or `wait_op` fall in the same cycle, the take wins and the low-power state is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 1 | Interrupt request pending |
| irq_en | input | 1 | Interrupt enabled |
| bcc1_valid | input | 1 | One-word conditional branch decoded this cycle |
| bcc1_taken | input | 1 | Condition outcome of that branch |
| rep_start | input | 1 | Repeat loop begins |
| rep_end | input | 1 | Repeat loop finishes this cycle |
| instr_done | input | 1 | An instruction completes this cycle |
| stop_op | input | 1 | Stop instruction executes |
| wait_op | input | 1 | Wait instruction executes |
| ws_stall | input | 1 | Memory wait-state stall |
| exec_len | input | EXEC_W | Execution cycles of the instruction being interrupted |
| take_int | output | 1 | Accept-interrupt pulse |
| nop_inject | output | 1 | Force a NOP into the pipeline |
| fetch_hold | output | 1 | Instruction fetch suspended |
| wake | output | 1 | Leave the wait state |
| arb_en | output | 1 | Interrupt arbitration enabled |

## Verification
`take_int`, `wake` and `fetch_hold` depend only on registered state and the inputs of the current cycle, so each is due in the very cycle its stimulus is applied. The counter-driven effects (window closure, blackout, NOP strobes) appear from the cycle after the edge that loads them. The bench drives inputs at the falling edge and samples one time unit later, before the next rising edge. A behavioural reference model is updated right after that rising edge, so every comparison pairs the model's state with the same-cycle inputs. Directed counts of the gap between consecutive takes pin down the blackout length, both stalled and unstalled.

// File: rtl/int_win_pkg.sv
package int_win_pkg;

    typedef enum logic [1:0] {
        PW_RUN  = 2'd0,
        PW_STOP = 2'd1,
        PW_WAIT = 2'd2
    } pw_state_e;

    // decode hints that shape the window
    typedef struct packed {
        logic bcc_valid;
        logic bcc_taken;
        logic rep_start;
        logic rep_end;
        logic instr_done;
    } dec_hint_t;

    // number of instructions shielded after a not-taken short branch
    localparam int SHADOW_LEN = 2;

    function automatic int blackout_span(input int exec_cyc, input int nops, input int call_cyc);
        return exec_cyc + nops + call_cyc;
    endfunction

endpackage

// File: rtl/iwc_window_gate.sv
module iwc_window_gate
    import int_win_pkg::*;
#(
    parameter int SHADOW = SHADOW_LEN
) (
    input  logic      clk,
    input  logic      rst,
    input  dec_hint_t hint,
    output logic      win_open,
    output logic      fetch_hold
);
    localparam int SH_W = $clog2(SHADOW + 1);

    logic [SH_W-1:0] shadow_q;
    logic            rep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (hint.bcc_valid && !hint.bcc_taken) begin
            shadow_q <= SH_W'(SHADOW);
        end else if (hint.instr_done && shadow_q != '0) begin
            shadow_q <= shadow_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_q <= 1'b0;
        end else if (hint.rep_start) begin
            rep_q <= 1'b1;
        end else if (hint.rep_end) begin
            rep_q <= 1'b0;
        end
    end

    always_comb begin
        win_open   = (shadow_q == '0) && !hint.rep_start && !rep_q;
        fetch_hold = rep_q;
    end

    // R4: loop stays active until its end is signalled
    assert_rep_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (rep_q && !hint.rep_end && !hint.rep_start) |=> rep_q);

    // R2: an untaken short branch closes the window on the next cycle
    assert_shadow_closes_R2: assert property (@(posedge clk) disable iff (rst)
        (hint.bcc_valid && !hint.bcc_taken) |=> !win_open);

endmodule

// File: rtl/iwc_blackout_timer.sv
module iwc_blackout_timer
    import int_win_pkg::*;
#(
    parameter int EXEC_W      = 4,
    parameter int NOP_SLOTS   = 3,
    parameter int CALL_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              stall,
    input  logic [EXEC_W-1:0] exec_len,
    output logic              arb_en,
    output logic              nop_inject
);
    localparam int MAX_SPAN = blackout_span((1 << EXEC_W) - 1, NOP_SLOTS, CALL_CYCLES);
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);
    localparam int NOP_W    = $clog2(NOP_SLOTS + 1);
    localparam int FIXED    = NOP_SLOTS + CALL_CYCLES;

    logic [CNT_W-1:0] blk_q;
    logic [NOP_W-1:0] nop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= '0;
            nop_q <= '0;
        end else if (take) begin
            blk_q <= CNT_W'(exec_len) + CNT_W'(FIXED);
            nop_q <= NOP_W'(NOP_SLOTS);
        end else if (!stall) begin
            if (blk_q != '0) blk_q <= blk_q - 1'b1;
            if (nop_q != '0) nop_q <= nop_q - 1'b1;
        end
    end

    always_comb begin
        arb_en     = (blk_q == '0);
        nop_inject = (nop_q != '0);
    end

    // R9: a stall freezes the blackout count
    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (stall && !take && blk_q != '0) |=> (blk_q == $past(blk_q)));

    // R10: the NOP count is frozen by a stall as well
    assert_nop_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (stall && !take && nop_q != '0) |=> (nop_q == $past(nop_q)));

endmodule

// File: rtl/iwc_power_fsm.sv
module iwc_power_fsm
    import int_win_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      take,
    input  logic      stop_op,
    input  logic      wait_op,
    output pw_state_e state,
    output logic      wake
);
    pw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_RUN: begin
                if (!take && stop_op)      state_d = PW_STOP;
                else if (!take && wait_op) state_d = PW_WAIT;
            end
            PW_WAIT: if (req) state_d = PW_RUN;
            PW_STOP: state_d = PW_STOP;
            default: state_d = PW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PW_RUN;
        else     state_q <= state_d;
    end

    assign state = state_q;
    assign wake  = (state_q == PW_WAIT) && req;

    // R5: stop is left only through reset
    assert_stop_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_STOP) |=> (state_q == PW_STOP));

    // R12: an accepted interrupt keeps the core running
    assert_take_keeps_run_R12: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_RUN && take) |=> (state_q == PW_RUN));

endmodule

// File: rtl/int_accept_window.sv
module int_accept_window
    import int_win_pkg::*;
#(
    parameter int EXEC_W      = 4,
    parameter int NOP_SLOTS   = 3,
    parameter int CALL_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_pend,
    input  logic              irq_en,
    input  logic              bcc1_valid,
    input  logic              bcc1_taken,
    input  logic              rep_start,
    input  logic              rep_end,
    input  logic              instr_done,
    input  logic              stop_op,
    input  logic              wait_op,
    input  logic              ws_stall,
    input  logic [EXEC_W-1:0] exec_len,
    output logic              take_int,
    output logic              nop_inject,
    output logic              fetch_hold,
    output logic              wake,
    output logic              arb_en
);
    dec_hint_t hint;
    pw_state_e pw_state;
    logic      win_open;
    logic      req;

    always_comb begin
        hint.bcc_valid  = bcc1_valid;
        hint.bcc_taken  = bcc1_taken;
        hint.rep_start  = rep_start;
        hint.rep_end    = rep_end;
        hint.instr_done = instr_done;
        req             = irq_pend && irq_en;
        take_int        = req && win_open && arb_en && (pw_state != PW_STOP);
    end

    iwc_window_gate #(.SHADOW(SHADOW_LEN)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .hint       (hint),
        .win_open   (win_open),
        .fetch_hold (fetch_hold)
    );

    iwc_blackout_timer #(
        .EXEC_W      (EXEC_W),
        .NOP_SLOTS   (NOP_SLOTS),
        .CALL_CYCLES (CALL_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .take       (take_int),
        .stall      (ws_stall),
        .exec_len   (exec_len),
        .arb_en     (arb_en),
        .nop_inject (nop_inject)
    );

    iwc_power_fsm u_power (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .take    (take_int),
        .stop_op (stop_op),
        .wait_op (wait_op),
        .state   (pw_state),
        .wake    (wake)
    );

    // R11: a take is never followed directly by another take
    assert_take_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        take_int |=> !take_int);

    // R8: acceptance starts the arbitration blackout
    assert_blackout_starts_R8: assert property (@(posedge clk) disable iff (rst)
        take_int |=> !arb_en);

    // R4: nothing is taken while a repeat loop begins
    assert_rep_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        rep_start |-> !take_int);

    // R10: NOP slots run only while arbitration is off
    assert_nop_in_blackout_R10: assert property (@(posedge clk) disable iff (rst)
        nop_inject |-> !arb_en);

endmodule

// File: tb/int_accept_window_bench.sv
module int_accept_window_bench;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 4;
    localparam int NOPS = 3;
    localparam int CALLC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_pend = 0, irq_en = 0, bcc1_valid = 0, bcc1_taken = 0;
    logic rep_start = 0, rep_end = 0, instr_done = 0, stop_op = 0, wait_op = 0, ws_stall = 0;
    logic [EW-1:0] exec_len = 4'd4;
    logic take_int, nop_inject, fetch_hold, wake, arb_en;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    int m_state = 0;   // 0 run, 1 stop, 2 wait
    int m_shadow = 0;
    int m_rep = 0;
    int m_blk = 0;
    int m_nop = 0;
    bit last_take = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_accept_window #(.EXEC_W(EW), .NOP_SLOTS(NOPS), .CALL_CYCLES(CALLC)) u_int_accept_window (
        .clk(clk), .rst(rst), .irq_pend(irq_pend), .irq_en(irq_en),
        .bcc1_valid(bcc1_valid), .bcc1_taken(bcc1_taken), .rep_start(rep_start),
        .rep_end(rep_end), .instr_done(instr_done), .stop_op(stop_op), .wait_op(wait_op),
        .ws_stall(ws_stall), .exec_len(exec_len), .take_int(take_int),
        .nop_inject(nop_inject), .fetch_hold(fetch_hold), .wake(wake), .arb_en(arb_en)
    );

    task automatic chk(input string nm, input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, nm, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // one clock cycle: compare against the model, then advance the model
    task automatic cyc();
        bit req, opn, e_take, e_wake;
        #1;
        req    = irq_pend && irq_en;
        opn    = (m_shadow == 0) && !rep_start && (m_rep == 0);
        e_take = req && opn && (m_blk == 0) && (m_state != 1);
        e_wake = (m_state == 2) && req;
        if (!rst) begin
            chk("take_int",   cur_req, int'(take_int),   int'(e_take));
            chk("wake",       cur_req, int'(wake),       int'(e_wake));
            chk("arb_en",     cur_req, int'(arb_en),     int'(m_blk == 0));
            chk("nop_inject", cur_req, int'(nop_inject), int'(m_nop != 0));
            chk("fetch_hold", cur_req, int'(fetch_hold), m_rep);
        end
        last_take = take_int;
        @(posedge clk);
        if (rst) begin
            m_state = 0; m_shadow = 0; m_rep = 0; m_blk = 0; m_nop = 0;
        end else begin
            if (e_take) begin
                m_blk = int'(exec_len) + NOPS + CALLC;
                m_nop = NOPS;
            end else if (!ws_stall) begin
                if (m_blk > 0) m_blk--;
                if (m_nop > 0) m_nop--;
            end
            if (bcc1_valid && !bcc1_taken) m_shadow = 2;
            else if (instr_done && m_shadow > 0) m_shadow--;
            if (rep_start) m_rep = 1;
            else if (rep_end) m_rep = 0;
            if (m_state == 0) begin
                if (!e_take && stop_op) m_state = 1;
                else if (!e_take && wait_op) m_state = 2;
            end else if (m_state == 2 && req) begin
                m_state = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        int gap;
        @(negedge clk);
        rst = 1; idle(2);
        rst = 0;
        cur_req = "R1";
        #1;
        chk("reset arb_en", "R1", int'(arb_en), 1);
        chk("reset fetch_hold", "R1", int'(fetch_hold), 0);
        #(-0);
        idle(3);

        // R7 / R8 / R10 / R11: held request, unstalled blackout
        cur_req = "R8";
        irq_pend = 1; irq_en = 1;
        cyc();
        chk("first take", "R7", int'(last_take), 1);
        gap = 0;
        do begin cyc(); gap++; end while (!last_take && gap < 40);
        chk("take gap E=4", "R8", gap, 11);
        // R9: two stall cycles in the blackout
        cur_req = "R9";
        cyc();
        ws_stall = 1; cyc(); cyc(); ws_stall = 0;
        gap = 3;
        do begin cyc(); gap++; end while (!last_take && gap < 40);
        chk("take gap stalled", "R9", gap, 13);
        // R10: stall during the NOP slots, shorter instruction
        cur_req = "R10";
        exec_len = 4'd1;
        ws_stall = 1; cyc(); ws_stall = 0;
        idle(10);
        irq_pend = 0; exec_len = 4'd4;
        idle(12);

        // R2: untaken one-word branch
        cur_req = "R2";
        bcc1_valid = 1; bcc1_taken = 0; cyc(); bcc1_valid = 0;
        irq_pend = 1; cyc();
        chk("shadow closed", "R2", int'(last_take), 0);
        instr_done = 1; cyc(); cyc(); instr_done = 0;
        chk("shadow closed at 2nd done", "R2", int'(last_take), 0);
        cyc();
        chk("shadow reopened", "R2", int'(last_take), 1);
        irq_pend = 0; idle(12);

        // R3: taken branch keeps window open
        cur_req = "R3";
        bcc1_valid = 1; bcc1_taken = 1; cyc(); bcc1_valid = 0; bcc1_taken = 0;
        irq_pend = 1; cyc();
        chk("taken branch open", "R3", int'(last_take), 1);
        irq_pend = 0; idle(12);

        // R4: repeat loop
        cur_req = "R4";
        irq_pend = 1; rep_start = 1; cyc(); rep_start = 0;
        chk("rep_start closed", "R4", int'(last_take), 0);
        idle(4);
        rep_end = 1; cyc(); rep_end = 0;
        chk("rep_end closed", "R4", int'(last_take), 0);
        cyc();
        chk("after loop open", "R4", int'(last_take), 1);
        chk("fetch resumed", "R4", int'(fetch_hold), 0);
        irq_pend = 0; idle(12);

        // R12: take wins over wait
        cur_req = "R12";
        irq_pend = 1; wait_op = 1; cyc(); wait_op = 0; irq_pend = 0;
        idle(12);

        // R6: wait state
        cur_req = "R6";
        wait_op = 1; cyc(); wait_op = 0;
        irq_pend = 1; irq_en = 0; idle(3);
        chk("no wake when disabled", "R6", int'(wake), 0);
        irq_en = 1; #1;
        chk("wake same cycle", "R6", int'(wake), 1);
        cyc();
        irq_pend = 0; idle(12);

        // R5: stop ignores everything
        cur_req = "R5";
        stop_op = 1; cyc(); stop_op = 0;
        irq_pend = 1; idle(8);
        chk("stopped no take", "R5", int'(last_take), 0);
        irq_pend = 0;
        rst = 1; idle(2); rst = 0;
        cur_req = "R1";
        idle(2);

        summary();
        done = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R11 actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule